// File: doc/BRIEF.md
# Clock Mode Select Controller

This block holds the mode request for a microcontroller clock generator and decides which clock mode is actually driven to the oscillator, FLL and clock multiplexer logic. Software writes a 2-bit mode through a valid/ready write port. The block keeps that request in a readable field and shows the mode it has put in force on a separate output. A 1-bit pending flag covers the time between the two.

The two external-reference modes need the external oscillator pins. The first accepted write after reset decides whether those pins are reserved. If that first write picks an internal mode, every later request for an external mode is discarded until the next reset. External modes only take effect when the synchronized reference-ready status is high. If that status drops while an external mode is in force, the block falls back to self-clocked mode and keeps the request pending. An off-mode input freezes both the request and the mode in force.

Write port rules: a write transfers on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while a mode change is pending or while off mode is asserted. A write offered while `wr_ready` is low is dropped, not held, so software retries after polling. An accepted-looking write to an external mode after an internal first write is also dropped.

Top module: `clk_mode_select`

## Requirements
- R1: After reset, `rd_mode` = 00, `active_mode` = 00, `pending` = 0, `pins_reserved` = 0, `wr_ready` = 1 and `status` = 0.
- R2: Mode encoding: 00 self-clocked, 01 FLL with internal reference, 10 FLL bypassed with external reference, 11 FLL with external reference. An accepted write of 00 or 01 appears on `rd_mode` after that edge and on `active_mode` one edge later.
- R3: A requested mode with bit 1 set does not become active while the synchronized ready is low. It becomes active on the edge after the synchronized ready is high. The synchronized ready follows `ext_ready` after `READY_SYNC_STAGES` edges.
- R4: While `pending` is high, `wr_ready` is low and an offered write leaves `rd_mode` unchanged.
- R5: If the first accepted write after reset has bit 1 = 0, every later write with bit 1 = 1 leaves `rd_mode` unchanged until reset. Writes with bit 1 = 0 are still accepted.
- R6: If the first accepted write after reset has bit 1 = 1, `pins_reserved` goes high and stays high until reset. Later writes of any mode are accepted.
- R7: While `off_mode` is high, `wr_ready` is low and neither `rd_mode` nor `active_mode` changes.
- R8: If the synchronized ready is low while `active_mode` has bit 1 set, `active_mode` becomes 00 on the next edge. `rd_mode` keeps the request and `pending` is high.
- R9: `status` bit 0 = `pins_reserved`, bit 1 = synchronized ready, bit 2 = `pending`, and all other bits are 0.
- R10: `pending` is high exactly when `rd_mode` differs from `active_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Mode write offered |
| wr_mode | input | 2 | Mode value to write |
| wr_ready | output | 1 | Block can take a mode write |
| ext_ready | input | 1 | Asynchronous external-reference-stable indication |
| off_mode | input | 1 | Clock generator in off mode; freezes mode state |
| rd_mode | output | 2 | Requested mode as read back from the control field |
| active_mode | output | 2 | Mode currently in force |
| pending | output | 1 | Request not yet in force |
| pins_reserved | output | 1 | External oscillator pins reserved since reset |
| status | output | STAT_W | Read-only status word |

## Verification
The properties assume that `ext_ready` is an asynchronous level that only matters after it passes the synchronizer. They also assume that `off_mode` and the write signals change away from the active edge, and the bench drives every input on the falling edge for this reason. The stimulus holds `ext_ready` stable for longer than the synchronizer depth whenever a cycle-exact result is checked. The stimulus offers writes while the port is not ready, during a pending change, in off mode, and after the lock has been set. Each of these is done on purpose, so that the drop rules are observed on `rd_mode`.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SELF       = 2'b00,
    MODE_FLL_INT    = 2'b01,
    MODE_BYPASS_EXT = 2'b10,
    MODE_FLL_EXT    = 2'b11
  } clk_mode_e;

  // bit positions inside the status word; bit 1 is polled by software
  localparam int STAT_RSV_BIT  = 0;
  localparam int STAT_RDY_BIT  = 1;
  localparam int STAT_PEND_BIT = 2;

  // bit 1 of a mode marks the modes that need the external pins
  function automatic logic needs_ext(input logic [MODE_W-1:0] m);
    return m[MODE_W-1];
  endfunction

endpackage

// File: rtl/ready_sync.sv
module ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], async_in};
      end
      assign sync_out = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mode_request_reg.sv
module mode_request_reg
  import clk_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [MODE_W-1:0] req_mode,
  output logic              reserved,
  output logic              locked_low
);

  logic              seen_q;
  logic              rsv_q;
  logic              lock_q;
  logic [MODE_W-1:0] req_q;
  logic              blocked;
  logic              taken;

  // an external mode is refused once the pins were left unreserved
  assign blocked = lock_q && needs_ext(wr_mode);
  assign taken   = wr_valid && wr_ready && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= MODE_SELF;
      seen_q <= 1'b0;
      rsv_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (taken) begin
      req_q <= wr_mode;
      if (!seen_q) begin
        seen_q <= 1'b1;
        rsv_q  <= needs_ext(wr_mode);
        lock_q <= !needs_ext(wr_mode);
      end
    end
  end

  assign req_mode   = req_q;
  assign reserved   = rsv_q;
  assign locked_low = lock_q;

endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer
  import clk_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              ref_ok,
  input  logic              off_mode,
  output logic [MODE_W-1:0] act_mode,
  output logic              pending
);

  logic [MODE_W-1:0] act_q;
  logic [MODE_W-1:0] act_d;

  always_comb begin
    act_d = act_q;
    if (!off_mode) begin
      if (needs_ext(act_q) && !ref_ok) begin
        act_d = MODE_SELF;
      end else if (req_mode != act_q) begin
        if (!needs_ext(req_mode) || ref_ok) act_d = req_mode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= MODE_SELF;
    else        act_q <= act_d;
  end

  assign act_mode = act_q;
  assign pending  = (req_mode != act_q);

endmodule

// File: rtl/clk_mode_select.sv
module clk_mode_select
  import clk_mode_pkg::*;
#(
  parameter int READY_SYNC_STAGES = 2,
  parameter int STAT_W            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_mode,
  output logic              wr_ready,
  input  logic              ext_ready,
  input  logic              off_mode,
  output logic [1:0]        rd_mode,
  output logic [1:0]        active_mode,
  output logic              pending,
  output logic              pins_reserved,
  output logic [STAT_W-1:0] status
);

  logic              rdy_s;
  logic              locked_low;
  logic [MODE_W-1:0] req_mode;
  logic [MODE_W-1:0] act_mode;
  logic              pend;
  logic              rsv;

  ready_sync #(.STAGES(READY_SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_ready),
    .sync_out (rdy_s)
  );

  assign wr_ready = !pend && !off_mode;

  mode_request_reg u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_mode    (wr_mode),
    .req_mode   (req_mode),
    .reserved   (rsv),
    .locked_low (locked_low)
  );

  mode_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_mode (req_mode),
    .ref_ok   (rdy_s),
    .off_mode (off_mode),
    .act_mode (act_mode),
    .pending  (pend)
  );

  always_comb begin
    status                = '0;
    status[STAT_RSV_BIT]  = rsv;
    status[STAT_RDY_BIT]  = rdy_s;
    status[STAT_PEND_BIT] = pend;
  end

  assign rd_mode       = req_mode;
  assign active_mode   = act_mode;
  assign pending       = pend;
  assign pins_reserved = rsv;

endmodule

// File: rtl/clk_mode_select_chk.sv
module clk_mode_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [1:0] wr_mode,
  input logic       wr_ready,
  input logic       off_mode,
  input logic       rdy_s,
  input logic       locked_low,
  input logic [1:0] rd_mode,
  input logic [1:0] active_mode,
  input logic       pins_reserved
);

  // R2
  int_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_mode[1]) |=> (rd_mode == $past(wr_mode)));

  // R3
  ext_waits_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_s && !active_mode[1]) |=> !active_mode[1]);

  // R4
  dropped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(rd_mode));

  // R5
  lock_refuses_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_low && wr_valid && wr_mode[1]) |=> $stable(rd_mode));

  // R6
  reserve_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_reserved |=> pins_reserved);

  // R7
  off_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_mode |=> ($stable(active_mode) && $stable(rd_mode)));

  // R8
  ref_loss_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_s && active_mode[1] && !off_mode) |=> (active_mode == 2'b00));

endmodule

bind clk_mode_select clk_mode_select_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_mode       (wr_mode),
  .wr_ready      (wr_ready),
  .off_mode      (off_mode),
  .rdy_s         (rdy_s),
  .locked_low    (locked_low),
  .rd_mode       (rd_mode),
  .active_mode   (active_mode),
  .pins_reserved (pins_reserved)
);

// File: tb/clk_mode_select_bench.sv
`timescale 1ns/1ps
module clk_mode_select_bench;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_mode = 2'b00;
  logic       ext_ready = 1'b0;
  logic       off_mode = 1'b0;
  logic       wr_ready;
  logic [1:0] rd_mode;
  logic [1:0] active_mode;
  logic       pending;
  logic       pins_reserved;
  logic [7:0] status;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  clk_mode_select #(.READY_SYNC_STAGES(SYNC), .STAT_W(8)) u_clk_mode_select (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_mode(wr_mode),
    .wr_ready(wr_ready), .ext_ready(ext_ready), .off_mode(off_mode),
    .rd_mode(rd_mode), .active_mode(active_mode), .pending(pending),
    .pins_reserved(pins_reserved), .status(status)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; off_mode = 1'b0; ext_ready = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  // offer one write for one edge, regardless of wr_ready
  task automatic wr(input logic [1:0] m);
    wr_valid = 1'b1; wr_mode = m;
    step(1);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_mode", rd_mode, 0);
    chk("R1 active", active_mode, 0);
    chk("R1 pending", pending, 0);
    chk("R1 reserved", pins_reserved, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 status", status, 0);
  endtask

  task automatic t_internal_lock();
    do_reset();
    ext_ready = 1'b1; step(SYNC + 1);
    wr(2'b01);
    chk("R2 rd_mode 01", rd_mode, 8'h1);
    chk("R10 pending during change", pending, 1);
    chk("R4 wr_ready low", wr_ready, 0);
    step(1);
    chk("R2 active 01", active_mode, 8'h1);
    chk("R10 pending cleared", pending, 0);
    wr(2'b10);
    chk("R5 ext write dropped", rd_mode, 8'h1);
    wr(2'b11);
    chk("R5 ext write 11 dropped", rd_mode, 8'h1);
    wr(2'b00);
    step(1);
    chk("R5 internal write kept", active_mode, 8'h0);
    chk("R5 reserved low", pins_reserved, 0);
  endtask

  task automatic t_external_wait();
    do_reset();
    wr(2'b10);
    chk("R6 reserved", pins_reserved, 1);
    chk("R3 rd_mode 10", rd_mode, 8'h2);
    step(4);
    chk("R3 held while not ready", active_mode, 8'h0);
    chk("R9 status pending+rsv", status, 8'h05);
    wr(2'b01);
    chk("R4 write during pending dropped", rd_mode, 8'h2);
    ext_ready = 1'b1;
    step(SYNC);
    chk("R9 status ready bit", status[1], 1);
    chk("R3 not yet active", active_mode, 8'h0);
    step(1);
    chk("R3 bypass active", active_mode, 8'h2);
    chk("R10 pending low", pending, 0);
    wr(2'b01); step(1);
    chk("R6 later internal accepted", active_mode, 8'h1);
    wr(2'b11); step(1);
    chk("R6 later ext accepted", active_mode, 8'h3);
  endtask

  task automatic t_fallback();
    // continues from active 11 with ready high
    ext_ready = 1'b0;
    step(SYNC);
    chk("R8 still 11 before sync", active_mode, 8'h3);
    step(1);
    chk("R8 fell back", active_mode, 8'h0);
    chk("R8 request kept", rd_mode, 8'h3);
    chk("R8 pending", pending, 1);
    ext_ready = 1'b1;
    step(SYNC + 1);
    chk("R8 re-engaged", active_mode, 8'h3);
  endtask

  task automatic t_off();
    do_reset();
    wr(2'b01); step(1);
    off_mode = 1'b1;
    step(1);
    chk("R7 wr_ready low", wr_ready, 0);
    wr(2'b00); step(2);
    chk("R7 request held", rd_mode, 8'h1);
    chk("R7 active held", active_mode, 8'h1);
    off_mode = 1'b0;
    do_reset();
    wr(2'b10);
    off_mode = 1'b1; ext_ready = 1'b1;
    step(SYNC + 3);
    chk("R7 frozen during off", active_mode, 8'h0);
    chk("R7 request kept", rd_mode, 8'h2);
    off_mode = 1'b0;
    step(1);
    chk("R7 resumes after off", active_mode, 8'h2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_internal_lock();
        t_external_wait();
        t_fallback();
        t_off();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule